// File: doc/BRIEF.md
# Line Buffer Power-Up Initializer

This block drives the control pins of a dual-port serial line buffer during power-up so that both address pointers end in a known state before any real traffic reaches it. The buffer's pointers hold arbitrary values at power-on, and the buffer only recovers them through a fixed routine. On each port, the block runs a minimum number of enabled accesses. It then applies a single pointer-reset strobe. All control pins are active low.

A power-good input stands in for supply detection. The block waits a programmable settle time, counted in user clock cycles, while power-good stays high. The write and read sequences then run at the same time, each on its own port clock. A mode input selects the longer form, which places one extra pointer reset in front of the dummy accesses. This form is for systems where the port clocks may have toggled before the supply was stable. When both ports are finished, a done flag rises in the user clock domain. The dummy count is a parameter, and elaboration rejects any value below 18.

Top module: `line_init_seq`

## Requirements
- R1: While `rst_n` is low, and after its release until the settle time has elapsed, `wr_en_n`, `wr_ptr_rst_n`, `rd_en_n` and `rd_ptr_rst_n` are all high and `init_done` is low.
- R2: Neither port shows any low enable or reset until `pwr_good` has been high for at least SETTLE_CYCLES consecutive `clk` cycles. The first activity appears no more than 16 `clk` cycles after that point.
- R3: If `pwr_good` falls before the settle time completes, the count restarts from zero and runs for a full SETTLE_CYCLES after `pwr_good` rises again.
- R4: In normal mode (`long_mode` = 0), the write port holds `wr_en_n` low for exactly DUMMY_CYCLES consecutive `wr_clk` cycles. In the next cycle it drives `wr_ptr_rst_n` low, and it then goes idle.
- R5: In normal mode, the read port behaves in the same way on `rd_clk`: DUMMY_CYCLES consecutive cycles with `rd_en_n` low, then one cycle with `rd_ptr_rst_n` low.
- R6: In long mode (`long_mode` = 1), each port runs one reset cycle, then DUMMY_CYCLES dummy cycles, then one reset cycle, all back to back. `long_mode` is sampled once when the settle time ends, and later changes have no effect.
- R7: On each port, the enable and the reset strobe are never low in the same cycle, and every reset strobe lasts exactly one port clock cycle.
- R8: `init_done` stays low until both port sequences have ended. It rises within 20 `clk` cycles after that, and it stays high until the next `rst_n` assertion.
- R9: Once both sequences have ended, all four control outputs stay high whatever `pwr_good` and `long_mode` do.
- R10: The two ports run on unrelated clocks of different rates, and each one completes its own sequence independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock; runs the settle count and the done flag |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| pwr_good | input | 1 | High while the supply is within range |
| long_mode | input | 1 | 1 selects reset–dummy–reset, 0 selects dummy–reset |
| wr_clk | input | 1 | Write port clock of the line buffer |
| rd_clk | input | 1 | Read port clock of the line buffer |
| wr_en_n | output | 1 | Write enable to the buffer, active low |
| wr_ptr_rst_n | output | 1 | Write pointer reset to the buffer, active low |
| rd_en_n | output | 1 | Read enable to the buffer, active low |
| rd_ptr_rst_n | output | 1 | Read pointer reset to the buffer, active low |
| init_done | output | 1 | High once both pointers have been initialized |

## Verification
A port sequencer whose dummy counter is off by one shows up at that port before its final reset strobe. The run of enable-low cycles comes out one longer or one shorter, so the fault is visible within DUMMY_CYCLES port cycles of the first activity. A settle counter that is wrong, or that ignores a power-good drop, moves the first port activity earlier or later by a measurable number of user clock cycles. A fault in the done crossing shows as `init_done` rising while a scoreboard queue still holds expected strobes, or as `init_done` failing to rise within a few cycles after both queues have emptied.

// File: rtl/lbi_pkg.sv
`timescale 1ns/1ps
package lbi_pkg;
  // lowest dummy access count the buffer accepts before a pointer reset
  localparam int unsigned MIN_DUMMY = 18;
  // index 0 is the write port, index 1 the read port
  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_PRE,
    PS_DUMMY,
    PS_POST,
    PS_DONE
  } port_state_e;
endpackage

// File: rtl/lbi_rst_sync.sv
`timescale 1ns/1ps
module lbi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lbi_sync.sv
`timescale 1ns/1ps
module lbi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lbi_settle.sv
`timescale 1ns/1ps
module lbi_settle #(
  parameter int unsigned SETTLE_CYCLES = 20_000_000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic long_mode,
  output logic settled,
  output logic long_q
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);

  logic          pg_s;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          settled_q, settled_d;
  logic          long_r, long_d;

  lbi_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pwr_good),
    .q    (pg_s)
  );

  // count consecutive power-good cycles; a drop restarts the interval
  always_comb begin
    cnt_d     = cnt_q;
    settled_d = settled_q;
    long_d    = long_r;
    if (!settled_q) begin
      if (!pg_s) begin
        cnt_d = '0;
      end else if (cnt_q == CW'(SETTLE_CYCLES - 1)) begin
        settled_d = 1'b1;
        long_d    = long_mode;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      settled_q <= 1'b0;
      long_r    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      settled_q <= settled_d;
      long_r    <= long_d;
    end
  end

  assign settled = settled_q;
  assign long_q  = long_r;
endmodule

// File: rtl/lbi_port_seq.sv
`timescale 1ns/1ps
module lbi_port_seq
  import lbi_pkg::*;
#(
  parameter int unsigned DUMMY_CYCLES = 18,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic pclk,
  input  logic arst_n,
  input  logic settled,
  input  logic long_mode,
  output logic en_n,
  output logic ptr_rst_n,
  output logic done
);
  localparam int unsigned CW = $clog2(DUMMY_CYCLES + 1);

  if (DUMMY_CYCLES < MIN_DUMMY) begin : g_bad_count
    $error("DUMMY_CYCLES must be at least 18");
  end

  logic          prst_n;
  logic          settled_s;
  port_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_n_q, ptr_rst_n_q, done_q;

  lbi_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (pclk),
    .arst_n(arst_n),
    .srst_n(prst_n)
  );

  lbi_sync #(.STAGES(SYNC_STAGES)) u_settle_sync (
    .clk  (pclk),
    .rst_n(prst_n),
    .d    (settled),
    .q    (settled_s)
  );

  // long_mode is latched in the user domain before settled rises,
  // so it is stable by the time settled_s is seen here
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_IDLE: begin
        if (settled_s) begin
          state_d = long_mode ? PS_PRE : PS_DUMMY;
          cnt_d   = '0;
        end
      end
      PS_PRE:   state_d = PS_DUMMY;
      PS_DUMMY: begin
        if (cnt_q == CW'(DUMMY_CYCLES - 1)) state_d = PS_POST;
        else                                cnt_d   = cnt_q + 1'b1;
      end
      PS_POST:  state_d = PS_DONE;
      PS_DONE:  state_d = PS_DONE;
      default:  state_d = PS_IDLE;
    endcase
  end

  // outputs registered from the next state so the pins never glitch
  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      state_q     <= PS_IDLE;
      cnt_q       <= '0;
      en_n_q      <= 1'b1;
      ptr_rst_n_q <= 1'b1;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      en_n_q      <= (state_d != PS_DUMMY);
      ptr_rst_n_q <= !((state_d == PS_PRE) || (state_d == PS_POST));
      done_q      <= (state_d == PS_DONE);
    end
  end

  assign en_n      = en_n_q;
  assign ptr_rst_n = ptr_rst_n_q;
  assign done      = done_q;
endmodule

// File: rtl/line_init_seq.sv
`timescale 1ns/1ps
module line_init_seq
  import lbi_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 20_000_000,
  parameter int unsigned DUMMY_CYCLES  = 18,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic long_mode,
  input  logic wr_clk,
  input  logic rd_clk,
  output logic wr_en_n,
  output logic wr_ptr_rst_n,
  output logic rd_en_n,
  output logic rd_ptr_rst_n,
  output logic init_done
);
  logic                 rst_clk_n;
  logic                 settled;
  logic                 long_q;
  logic [NUM_PORTS-1:0] pclk, p_en_n, p_rst_n, p_done, done_s;
  logic                 done_d, done_q;

  lbi_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(rst_clk_n)
  );

  lbi_settle #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_settle (
    .clk      (clk),
    .rst_n    (rst_clk_n),
    .pwr_good (pwr_good),
    .long_mode(long_mode),
    .settled  (settled),
    .long_q   (long_q)
  );

  assign pclk = {rd_clk, wr_clk};

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    lbi_port_seq #(
      .DUMMY_CYCLES(DUMMY_CYCLES),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_seq (
      .pclk     (pclk[gp]),
      .arst_n   (rst_n),
      .settled  (settled),
      .long_mode(long_q),
      .en_n     (p_en_n[gp]),
      .ptr_rst_n(p_rst_n[gp]),
      .done     (p_done[gp])
    );

    lbi_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk  (clk),
      .rst_n(rst_clk_n),
      .d    (p_done[gp]),
      .q    (done_s[gp])
    );
  end

  always_comb done_d = &done_s;

  always_ff @(posedge clk or negedge rst_clk_n) begin
    if (!rst_clk_n) done_q <= 1'b0;
    else            done_q <= done_d;
  end

  assign wr_en_n      = p_en_n[0];
  assign wr_ptr_rst_n = p_rst_n[0];
  assign rd_en_n      = p_en_n[1];
  assign rd_ptr_rst_n = p_rst_n[1];
  assign init_done    = done_q;
endmodule

// File: rtl/lbi_checker.sv
`timescale 1ns/1ps
module lbi_checker #(
  parameter int unsigned DUMMY_CYCLES = 18
) (
  input logic clk,
  input logic rst_n,
  input logic wr_clk,
  input logic rd_clk,
  input logic wr_en_n,
  input logic wr_ptr_rst_n,
  input logic rd_en_n,
  input logic rd_ptr_rst_n,
  input logic init_done,
  input logic settled
);
  localparam int unsigned CW = $clog2(DUMMY_CYCLES + 2);

  logic [CW-1:0] wr_cnt, rd_cnt;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) wr_cnt <= '0;
    else if (!wr_en_n && (wr_cnt <= CW'(DUMMY_CYCLES))) wr_cnt <= wr_cnt + 1'b1;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) rd_cnt <= '0;
    else if (!rd_en_n && (rd_cnt <= CW'(DUMMY_CYCLES))) rd_cnt <= rd_cnt + 1'b1;
  end

  p_excl_wr_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !(!wr_en_n && !wr_ptr_rst_n));
  p_excl_rd_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(!rd_en_n && !rd_ptr_rst_n));
  p_pulse_wr_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_ptr_rst_n |=> wr_ptr_rst_n);
  p_pulse_rd_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_ptr_rst_n |=> rd_ptr_rst_n);
  p_no_early_wr_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!wr_en_n || !wr_ptr_rst_n) |-> settled);
  p_no_early_rd_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!rd_en_n || !rd_ptr_rst_n) |-> settled);
  p_dummy_cap_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_en_n |-> (wr_cnt < CW'(DUMMY_CYCLES)));
  p_post_full_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_ptr_rst_n |-> ((wr_cnt == '0) || (wr_cnt == CW'(DUMMY_CYCLES))));
  p_dummy_cap_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_en_n |-> (rd_cnt < CW'(DUMMY_CYCLES)));
  p_post_full_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_ptr_rst_n |-> ((rd_cnt == '0) || (rd_cnt == CW'(DUMMY_CYCLES))));
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_done_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (wr_cnt == CW'(DUMMY_CYCLES) && rd_cnt == CW'(DUMMY_CYCLES)));
  p_idle_wr_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
    init_done |-> (wr_en_n && wr_ptr_rst_n));
  p_idle_rd_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
    init_done |-> (rd_en_n && rd_ptr_rst_n));
endmodule

bind line_init_seq lbi_checker #(.DUMMY_CYCLES(DUMMY_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_clk      (wr_clk),
  .rd_clk      (rd_clk),
  .wr_en_n     (wr_en_n),
  .wr_ptr_rst_n(wr_ptr_rst_n),
  .rd_en_n     (rd_en_n),
  .rd_ptr_rst_n(rd_ptr_rst_n),
  .init_done   (init_done),
  .settled     (settled)
);

// File: tb/sim_line_init_seq.sv
`timescale 1ns/1ps
module sim_line_init_seq;
  localparam int SETTLE = 200;
  localparam int DUMMY  = 20;

  logic clk = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
  logic rst_n, pwr_good, long_mode;
  logic wr_en_n, wr_ptr_rst_n, rd_en_n, rd_ptr_rst_n, init_done;

  always #2.5 clk    = ~clk;
  always #3.5 wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  line_init_seq #(
    .SETTLE_CYCLES(SETTLE),
    .DUMMY_CYCLES (DUMMY),
    .SYNC_STAGES  (2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .long_mode(long_mode),
    .wr_clk(wr_clk), .rd_clk(rd_clk),
    .wr_en_n(wr_en_n), .wr_ptr_rst_n(wr_ptr_rst_n),
    .rd_en_n(rd_en_n), .rd_ptr_rst_n(rd_ptr_rst_n),
    .init_done(init_done)
  );

  int      checks = 0;
  int      fails  = 0;
  byte     wr_exp[$];
  byte     rd_exp[$];
  bit      wr_seen, rd_seen, wr_prev, rd_prev;
  bit      cur_long;
  string   idle_req = "R1";
  realtime t_pg;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected items: 0 = pointer reset cycle, 1 = dummy enabled cycle
  task automatic push_seq(input bit lng);
    if (lng) begin wr_exp.push_back(0); rd_exp.push_back(0); end
    repeat (DUMMY) begin wr_exp.push_back(1); rd_exp.push_back(1); end
    wr_exp.push_back(0);
    rd_exp.push_back(0);
  endtask

  task automatic mon(input logic en_n, input logic rp, ref byte q[$],
                     ref bit seen, ref bit prev, input string name,
                     input string req);
    bit  act;
    byte got, e;
    real dt;
    act = !en_n || !rp;
    if (!en_n && !rp) chk(1'b0, "R7", {name, " enable and reset low together"}, 1, 0);
    if (act) begin
      got = rp ? 8'sd1 : 8'sd0;
      if (!seen) begin
        dt = ($realtime - t_pg) / 5.0;
        chk(dt >= SETTLE && dt <= SETTLE + 16, "R2",
            {name, " first activity delay in clk cycles"}, int'(dt), SETTLE);
        seen = 1'b1;
      end else begin
        chk(prev, req, {name, " gap inside sequence"}, 0, 1);
      end
      if (q.size() == 0) begin
        chk(1'b0, idle_req, {name, " activity with nothing expected"}, got, -1);
      end else begin
        e = q.pop_front();
        chk(got == e, cur_long ? "R6" : req, {name, " sequence item"}, got, e);
      end
    end
    prev = act;
  endtask

  always @(negedge wr_clk) if (rst_n === 1'b1)
    mon(wr_en_n, wr_ptr_rst_n, wr_exp, wr_seen, wr_prev, "write", "R4");
  always @(negedge rd_clk) if (rst_n === 1'b1)
    mon(rd_en_n, rd_ptr_rst_n, rd_exp, rd_seen, rd_prev, "read", "R5");

  // R8: done must stay low while any expected strobe is outstanding
  always @(negedge clk)
    if (rst_n === 1'b1 && (wr_exp.size() != 0 || rd_exp.size() != 0))
      chk(init_done == 1'b0, "R8", "done before both sequences ended", init_done, 0);

  task automatic run(input bit lng, input bit glitch);
    rst_n = 1'b0; pwr_good = 1'b0; long_mode = lng; cur_long = lng;
    wr_seen = 1'b0; rd_seen = 1'b0; wr_prev = 1'b0; rd_prev = 1'b0;
    wr_exp.delete(); rd_exp.delete();
    idle_req = "R1";
    repeat (4) @(negedge clk);
    chk(wr_en_n && wr_ptr_rst_n && rd_en_n && rd_ptr_rst_n, "R1",
        "controls high in reset", {wr_en_n, wr_ptr_rst_n, rd_en_n, rd_ptr_rst_n}, 15);
    chk(init_done == 1'b0, "R1", "done low in reset", init_done, 0);
    rst_n = 1'b1;
    idle_req = "R2";
    repeat (40) @(negedge clk);
    chk(init_done == 1'b0, "R1", "done low before settle", init_done, 0);
    if (glitch) begin
      idle_req = "R3";
      pwr_good = 1'b1;
      repeat (SETTLE * 3 / 4) @(negedge clk);
      pwr_good = 1'b0;
      repeat (6) @(negedge clk);
    end
    idle_req = "R2";
    pwr_good = 1'b1;
    t_pg = $realtime;
    push_seq(lng);
    if (glitch) begin
      for (int i = 0; i < SETTLE + 100 && !wr_seen; i++) @(negedge clk);
      long_mode = !lng;   // R6: late change must not alter the sequence
    end
    for (int i = 0; i < 4000 && (wr_exp.size() != 0 || rd_exp.size() != 0); i++)
      @(negedge clk);
    chk(wr_exp.size() == 0 && rd_exp.size() == 0, "R10", "both ports completed",
        wr_exp.size() + rd_exp.size(), 0);
    for (int i = 0; i < 20 && !init_done; i++) @(negedge clk);
    chk(init_done == 1'b1, "R8", "done raised after completion", init_done, 1);
    idle_req = "R9";
    pwr_good = 1'b0;
    repeat (30) @(negedge clk);
    pwr_good = 1'b1;
    long_mode = !long_mode;
    repeat (30) @(negedge clk);
    chk(wr_en_n && wr_ptr_rst_n && rd_en_n && rd_ptr_rst_n, "R9",
        "controls idle after completion",
        {wr_en_n, wr_ptr_rst_n, rd_en_n, rd_ptr_rst_n}, 15);
    chk(init_done == 1'b1, "R8", "done held high", init_done, 1);
  endtask

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0; long_mode = 1'b0;
    run(1'b0, 1'b0);   // normal mode, R4 R5
    run(1'b1, 1'b0);   // long mode, R6
    run(1'b1, 1'b1);   // power-good drop R3, late mode change R6
    run(1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule